// File: doc/BRIEF.md
# Dual-Port Register Bank with Per-Port Write Permissions

This block holds a small set of shared control registers, one event-cause register and one event-enable register. Two independent memory-mapped slave ports reach the same storage. The processor port may write every bit. The host port may write only the bits that a per-register parameter mask allows. It can still read the protected bits, but its writes to them are dropped. Both ports may access the bank in the same cycle, and the block resolves that case itself.

Single-cycle event pulses set bits in the cause register. Each event is routed to exactly one of the two interrupt outputs, so one event never interrupts both masters. Software reads the cause register to learn which event fired, and writes 1 to a bit to clear it. A build parameter selects a single-port variant. In that variant the privilege of each access comes from an extra top address bit on the processor port, and the host port is ignored.

Top module: `dual_port_reg_bank`

Address map (bank word index): 0..NUM_REGS-1 general registers, NUM_REGS cause, NUM_REGS+1 enable. With the defaults these are 0-3 general, 4 cause and 5 enable. Addresses 6 and 7 are unmapped.

## Requirements
- R1: In the dual-port build, a processor-port write to a general register updates every byte whose enable bit is set (bit b of the byte enable covers data bits 8b+7..8b). The top processor address bit has no effect.
- R2: A host-port write changes only the bits set in that register's host mask (defaults: reg0 0x0000FFFF, reg1 0xFFFFFFFF, reg2 0x00000000, reg3 0x00FF00FF). All bits remain readable from the host port.
- R3: When both ports write the same register in the same cycle, bits written by the processor take the processor's data. The host's permitted bits apply only where the processor wrote nothing.
- R4: Each port returns read data on the clock edge after its read strobe, with no wait states and independently of the other port. A read returns the value from before any write in the same cycle, and the read data holds until the next read.
- R5: Cause register (address 4): a pulse on event input i sets bit i. Writing 1 to a permitted bit clears it. A set and a clear in the same cycle leave the bit set.
- R6: The host port may clear and enable only the host-routed events (mask 4'b1100, events 2 and 3). The processor port may clear and enable all events.
- R7: Enable register (address 5). The processor interrupt is the OR of enabled cause bits for events 0 and 1. The host interrupt is the same OR for events 2 and 3. Each event drives only its own line.
- R8: Reads of addresses 6 and 7 return zero, and writes to them have no effect. Bits above the event count in the cause and enable registers read zero.
- R9: After reset, every register, both read-data outputs and both interrupts are zero.
- R10: In the single-port build, the host port is ignored. A processor-port write with the top address bit high has full access, and with it low it gets the host masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| p_req_i | input | 1 | Processor port access strobe |
| p_we_i | input | 1 | Processor port write (1) or read (0) |
| p_addr_i | input | AW+1 (4) | Processor word address; top bit is privilege in single-port build |
| p_be_i | input | DATA_W/8 (4) | Processor byte enables |
| p_wdata_i | input | DATA_W (32) | Processor write data |
| p_rdata_o | output | DATA_W (32) | Processor read data |
| h_req_i | input | 1 | Host port access strobe |
| h_we_i | input | 1 | Host port write (1) or read (0) |
| h_addr_i | input | AW (3) | Host word address |
| h_be_i | input | DATA_W/8 (4) | Host byte enables |
| h_wdata_i | input | DATA_W (32) | Host write data |
| h_rdata_o | output | DATA_W (32) | Host read data |
| evt_i | input | NUM_EVENTS (4) | Event pulses |
| p_irq_o | output | 1 | Processor interrupt |
| h_irq_o | output | 1 | Host interrupt |

## Verification
The hardest condition to reach is two writes to the same register in the same cycle with overlapping byte enables. This is made worse when the target is the cause register and an event pulse lands in that same cycle. Uniform random addresses would rarely line these up. The random stimulus therefore copies the processor address onto the host port about a third of the time, and it raises event pulses while cause-register writes are in flight. Directed steps cover the fixed cases: host clears of processor-routed bits, and set-over-clear on the cause register. A second instance built single-port has its host port writing all ones on every cycle, to show that port is ignored.

// File: rtl/dprb_pkg.sv
package dprb_pkg;
  typedef enum logic {PRIV_LIMITED = 1'b0, PRIV_FULL = 1'b1} priv_e;

  function automatic int bank_words(input int nregs);
    return nregs + 2;
  endfunction
endpackage

// File: rtl/dprb_port.sv
module dprb_port
  import dprb_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NT  = 6,
  parameter int AW  = 3,
  localparam int BEW = DW / 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  priv_e                  priv_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [BEW-1:0]         be_i,
  input  logic [NT-1:0][DW-1:0]  full_mask_i,
  input  logic [NT-1:0][DW-1:0]  lim_mask_i,
  input  logic [NT-1:0][DW-1:0]  view_i,
  output logic [NT-1:0][DW-1:0]  bwe_o,
  output logic [DW-1:0]          rdata_o
);
  logic [DW-1:0] be_bits;
  logic [DW-1:0] rd_mux;

  always_comb begin
    for (int b = 0; b < BEW; b++) be_bits[b*8 +: 8] = {8{be_i[b]}};
  end

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      if (req_i && we_i && addr_i == AW'(k))
        bwe_o[k] = be_bits & ((priv_i == PRIV_FULL) ? full_mask_i[k] : lim_mask_i[k]);
      else
        bwe_o[k] = '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NT; k++)
      if (addr_i == AW'(k)) rd_mux = view_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (req_i && !we_i)    rdata_o <= rd_mux;
  end

  // read of an unmapped word yields zero one cycle later
  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && int'(addr_i) >= NT) |=> (rdata_o == '0));

  // read data is held between reads
  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/dprb_merge.sv
module dprb_merge #(
  parameter int DW  = 32,
  parameter bit W1C = 1'b0
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] p_bwe_i,
  input  logic [DW-1:0] p_wdata_i,
  input  logic [DW-1:0] h_bwe_i,
  input  logic [DW-1:0] h_wdata_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] next_o
);
  logic [DW-1:0] h_eff;
  logic [DW-1:0] wmask;
  logic [DW-1:0] wval;

  // processor owns every bit it writes; host fills the rest
  assign h_eff = h_bwe_i & ~p_bwe_i;
  assign wmask = p_bwe_i | h_eff;
  assign wval  = (p_wdata_i & p_bwe_i) | (h_wdata_i & h_eff);

  generate
    if (W1C) begin : g_w1c
      assign next_o = (old_i & ~wval) | set_i;
    end else begin : g_rw
      assign next_o = (old_i & ~wmask) | wval | set_i;
    end
  endgenerate
endmodule

// File: rtl/dprb_irq.sv
module dprb_irq #(
  parameter int DW = 32,
  parameter int NE = 4,
  parameter logic [NE-1:0] HOST_EVT = '0
) (
  input  logic [DW-1:0] cause_i,
  input  logic [DW-1:0] en_i,
  output logic          p_irq_o,
  output logic          h_irq_o
);
  localparam logic [DW-1:0] EVT_ALL  = DW'({NE{1'b1}});
  localparam logic [DW-1:0] HOST_SEL = DW'(HOST_EVT);
  localparam logic [DW-1:0] PROC_SEL = EVT_ALL & ~HOST_SEL;

  logic [DW-1:0] pend;
  assign pend    = cause_i & en_i;
  assign p_irq_o = |(pend & PROC_SEL);
  assign h_irq_o = |(pend & HOST_SEL);
endmodule

// File: rtl/dual_port_reg_bank.sv
module dual_port_reg_bank
  import dprb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 4,
  parameter int NUM_EVENTS  = 4,
  parameter bit SINGLE_PORT = 1'b0,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] HOST_WMASK =
    {32'h00FF_00FF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_FFFF},
  parameter logic [NUM_EVENTS-1:0] HOST_EVT_MASK = 4'b1100,
  localparam int NT  = bank_words(NUM_REGS),
  localparam int AW  = $clog2(NT),
  localparam int BEW = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p_req_i,
  input  logic              p_we_i,
  input  logic [AW:0]       p_addr_i,
  input  logic [BEW-1:0]    p_be_i,
  input  logic [DATA_W-1:0] p_wdata_i,
  output logic [DATA_W-1:0] p_rdata_o,
  input  logic              h_req_i,
  input  logic              h_we_i,
  input  logic [AW-1:0]     h_addr_i,
  input  logic [BEW-1:0]    h_be_i,
  input  logic [DATA_W-1:0] h_wdata_i,
  output logic [DATA_W-1:0] h_rdata_o,
  input  logic [NUM_EVENTS-1:0] evt_i,
  output logic              p_irq_o,
  output logic              h_irq_o
);
  localparam int CAUSE_IDX = NUM_REGS;
  localparam int EN_IDX    = NUM_REGS + 1;
  localparam logic [DATA_W-1:0] EVT_BITS = DATA_W'({NUM_EVENTS{1'b1}});

  logic [NT-1:0][DATA_W-1:0] full_mask, lim_mask;
  logic [NT-1:0][DATA_W-1:0] regs_q, regs_d;
  logic [NT-1:0][DATA_W-1:0] p_bwe, h_bwe;
  priv_e p_priv;
  logic  h_req_eff;

  assign p_priv    = SINGLE_PORT ? priv_e'(p_addr_i[AW]) : PRIV_FULL;
  assign h_req_eff = h_req_i & ~SINGLE_PORT;

  generate
    for (genvar k = 0; k < NT; k++) begin : g_word
      if (k < NUM_REGS) begin : g_gen
        assign full_mask[k] = '1;
        assign lim_mask[k]  = HOST_WMASK[k];
      end else begin : g_evt
        assign full_mask[k] = EVT_BITS;
        assign lim_mask[k]  = DATA_W'(HOST_EVT_MASK);
      end

      dprb_merge #(.DW(DATA_W), .W1C(k == CAUSE_IDX)) u_merge (
        .old_i     (regs_q[k]),
        .p_bwe_i   (p_bwe[k]),
        .p_wdata_i (p_wdata_i),
        .h_bwe_i   (h_bwe[k]),
        .h_wdata_i (h_wdata_i),
        .set_i     ((k == CAUSE_IDX) ? DATA_W'(evt_i) : '0),
        .next_o    (regs_d[k])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[k] <= '0;
        else         regs_q[k] <= regs_d[k];
      end

      if (k < NUM_REGS) begin : g_chk
        // host-only write leaves protected bits untouched
        assert_host_protect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (h_req_eff && h_we_i && h_addr_i == AW'(k) && p_bwe[k] == '0)
          |=> (((regs_q[k] ^ $past(regs_q[k])) & ~HOST_WMASK[k]) == '0));
        // processor-written bits carry processor data
        assert_proc_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (p_bwe[k] != '0) |=> ((regs_q[k] & $past(p_bwe[k])) == ($past(p_wdata_i) & $past(p_bwe[k]))));
      end
    end
  endgenerate

  dprb_port #(.DW(DATA_W), .NT(NT), .AW(AW)) u_pport (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (p_req_i),
    .we_i        (p_we_i),
    .priv_i      (p_priv),
    .addr_i      (p_addr_i[AW-1:0]),
    .be_i        (p_be_i),
    .full_mask_i (full_mask),
    .lim_mask_i  (lim_mask),
    .view_i      (regs_q),
    .bwe_o       (p_bwe),
    .rdata_o     (p_rdata_o)
  );

  dprb_port #(.DW(DATA_W), .NT(NT), .AW(AW)) u_hport (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (h_req_eff),
    .we_i        (h_we_i),
    .priv_i      (PRIV_LIMITED),
    .addr_i      (h_addr_i),
    .be_i        (h_be_i),
    .full_mask_i (full_mask),
    .lim_mask_i  (lim_mask),
    .view_i      (regs_q),
    .bwe_o       (h_bwe),
    .rdata_o     (h_rdata_o)
  );

  dprb_irq #(.DW(DATA_W), .NE(NUM_EVENTS), .HOST_EVT(HOST_EVT_MASK)) u_irq (
    .cause_i (regs_q[CAUSE_IDX]),
    .en_i    (regs_q[EN_IDX]),
    .p_irq_o (p_irq_o),
    .h_irq_o (h_irq_o)
  );

  generate
    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_evt_chk
      assert_evt_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[e] |=> regs_q[CAUSE_IDX][e]);
    end
  endgenerate

  assert_host_irq_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_irq_o |-> ((regs_q[CAUSE_IDX] & DATA_W'(HOST_EVT_MASK)) != '0));
  assert_proc_irq_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_irq_o |-> ((regs_q[CAUSE_IDX] & EVT_BITS & ~DATA_W'(HOST_EVT_MASK)) != '0));
  assert_evt_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((regs_q[CAUSE_IDX] | regs_q[EN_IDX]) & ~EVT_BITS) == '0);
endmodule

// File: tb/dual_port_reg_bank_tb_top.sv
module dual_port_reg_bank_tb_top;
  localparam logic [3:0][31:0] HMASK = {32'h00FF_00FF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_FFFF};
  localparam logic [3:0] HEVT = 4'b1100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        p_req = 0, p_we = 0, h_req = 0, h_we = 0;
  logic [3:0]  p_addr = 0, p_be = 0, h_be = 0, evt = 0;
  logic [2:0]  h_addr = 0;
  logic [31:0] p_wdata = 0, h_wdata = 0;
  logic [31:0] p_rdata, h_rdata;
  logic        p_irq, h_irq;

  logic        sp_req = 0, sp_we = 0;
  logic [3:0]  sp_addr = 0, sp_be = 4'hF;
  logic [31:0] sp_wdata = 0;
  logic [31:0] sp_p_rdata, sp_h_rdata;
  logic        sp_p_irq, sp_h_irq;

  dual_port_reg_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .p_req_i(p_req), .p_we_i(p_we), .p_addr_i(p_addr), .p_be_i(p_be), .p_wdata_i(p_wdata), .p_rdata_o(p_rdata),
    .h_req_i(h_req), .h_we_i(h_we), .h_addr_i(h_addr), .h_be_i(h_be), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .evt_i(evt), .p_irq_o(p_irq), .h_irq_o(h_irq));

  // host port writes all ones on every cycle; must be ignored (R10)
  dual_port_reg_bank #(.SINGLE_PORT(1'b1)) dut_sp_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .p_req_i(sp_req), .p_we_i(sp_we), .p_addr_i(sp_addr), .p_be_i(sp_be), .p_wdata_i(sp_wdata), .p_rdata_o(sp_p_rdata),
    .h_req_i(1'b1), .h_we_i(1'b1), .h_addr_i(3'd1), .h_be_i(4'hF), .h_wdata_i(32'hFFFF_FFFF), .h_rdata_o(sp_h_rdata),
    .evt_i(4'h0), .p_irq_o(sp_p_irq), .h_irq_o(sp_h_irq));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m [6];

  function automatic logic [31:0] ex(input logic [3:0] be);
    for (int b = 0; b < 4; b++) ex[b*8 +: 8] = {8{be[b]}};
  endfunction
  function automatic logic [31:0] cmask(input int k);
    return (k < 4) ? 32'hFFFF_FFFF : 32'h0000_000F;
  endfunction
  function automatic logic [31:0] hmask(input int k);
    return (k < 4) ? HMASK[k] : {28'h0, HEVT};
  endfunction
  function automatic logic [31:0] rd(input logic [2:0] a);
    return (a < 3'd6) ? m[a] : 32'h0;
  endfunction
  function automatic string tag_of(input logic [2:0] a);
    if (a < 3'd4) return "R1";
    if (a == 3'd4) return "R5";
    if (a == 3'd5) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
    end
  endtask

  // called at a negedge; drives one cycle, checks results at next negedge
  task automatic step(input logic pr, input logic pw, input logic [3:0] pa, input logic [3:0] pb, input logic [31:0] pd,
                      input logic hr, input logic hw, input logic [2:0] ha, input logic [3:0] hb, input logic [31:0] hd,
                      input logic [3:0] ev, input string tg);
    logic [31:0] ep, eh, wc, wh, wr;
    bit prd, hrd;
    p_req = pr; p_we = pw; p_addr = pa; p_be = pb; p_wdata = pd;
    h_req = hr; h_we = hw; h_addr = ha; h_be = hb; h_wdata = hd; evt = ev;
    prd = pr && !pw; hrd = hr && !hw;
    ep = rd(pa[2:0]); eh = rd(ha);
    for (int k = 0; k < 6; k++) begin
      wc = (pr && pw && pa[2:0] == 3'(k)) ? ex(pb) & cmask(k) : 32'h0;
      wh = (hr && hw && ha == 3'(k)) ? ex(hb) & hmask(k) & ~wc : 32'h0;
      wr = (pd & wc) | (hd & wh);
      if (k == 4) m[k] = (m[k] & ~wr) | {28'h0, ev};
      else        m[k] = (m[k] & ~(wc | wh)) | wr;
    end
    @(negedge clk_i);
    p_req = 0; h_req = 0; evt = 0;
    if (prd) chk((tg == "") ? tag_of(pa[2:0]) : tg, "p_rdata", p_rdata, ep);
    if (hrd) chk((tg == "") ? "R2" : tg, "h_rdata", h_rdata, eh);
    chk("R7", "p_irq", {31'h0, p_irq}, {31'h0, |(m[4] & m[5] & 32'h3)});
    chk("R7", "h_irq", {31'h0, h_irq}, {31'h0, |(m[4] & m[5] & 32'hC)});
  endtask

  task automatic pwr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d, input string tg);
    step(1, 1, a, be, d, 0, 0, 0, 0, 0, 0, tg);
  endtask
  task automatic hwr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d, input string tg);
    step(0, 0, 0, 0, 0, 1, 1, a, be, d, 0, tg);
  endtask
  task automatic prd_t(input logic [3:0] a, input string tg);
    step(1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, tg);
  endtask
  task automatic hrd_t(input logic [2:0] a, input string tg);
    step(0, 0, 0, 0, 0, 1, 0, a, 0, 0, 0, tg);
  endtask

  task automatic sp_access(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [31:0] exp, input string tg);
    sp_req = 1; sp_we = w; sp_addr = a; sp_wdata = d;
    @(negedge clk_i);
    sp_req = 0;
    if (!w) chk(tg, "sp_rdata", sp_p_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int k = 0; k < 6; k++) m[k] = '0;
    repeat (3) @(negedge clk_i);
    chk("R9", "p_rdata reset", p_rdata, 0);
    chk("R9", "h_rdata reset", h_rdata, 0);
    chk("R9", "irq reset", {30'h0, p_irq, h_irq}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 6; k++) step(1, 0, 4'(k), 0, 0, 1, 0, 3'(k), 0, 0, 0, "R9");

    // host mask
    hwr(3'd2, 4'hF, 32'hFFFF_FFFF, "R2");
    hrd_t(3'd2, "R2");
    hwr(3'd0, 4'hF, 32'hFFFF_FFFF, "R2");
    prd_t(4'd0, "R2");
    hwr(3'd3, 4'hF, 32'hDEAD_BEEF, "R2");
    hrd_t(3'd3, "R2");
    // processor byte enables, top address bit ignored
    pwr(4'b1010, 4'b0101, 32'h1234_5678, "R1");
    prd_t(4'd2, "R1");
    pwr(4'd1, 4'hF, 32'hCAFE_F00D, "R1");
    prd_t(4'd1, "R1");
    // collision
    step(1, 1, 4'd3, 4'b0011, 32'hAAAA_AAAA, 1, 1, 3'd3, 4'hF, 32'h5555_5555, 0, "R3");
    prd_t(4'd3, "R3");
    step(1, 1, 4'd1, 4'b1100, 32'h0F0F_0F0F, 1, 1, 3'd1, 4'b0110, 32'hF0F0_F0F0, 0, "R3");
    hrd_t(3'd1, "R3");
    // read vs same-cycle write, independent ports
    step(1, 0, 4'd1, 0, 0, 1, 1, 3'd1, 4'hF, 32'h7777_7777, 0, "R4");
    step(1, 0, 4'd1, 0, 0, 1, 0, 3'd0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    chk("R4", "p_rdata hold", p_rdata, 32'h7777_7777);
    // events and interrupts
    pwr(4'd5, 4'hF, 32'hFFFF_FFFF, "R7");
    prd_t(4'd5, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0001, "R7");
    chk("R7", "proc irq only", {30'h0, p_irq, h_irq}, 2'b10);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0100, "R7");
    chk("R7", "both lines", {30'h0, p_irq, h_irq}, 2'b11);
    hwr(3'd4, 4'hF, 32'hFFFF_FFFF, "R6");
    prd_t(4'd4, "R6");
    chk("R6", "cause after host clear", p_rdata, 32'h1);
    hwr(3'd5, 4'hF, 32'h0, "R6");
    prd_t(4'd5, "R6");
    step(1, 1, 4'd4, 4'hF, 32'h1, 0, 0, 0, 0, 0, 4'b0001, "R5");
    prd_t(4'd4, "R5");
    pwr(4'd4, 4'hF, 32'h1, "R5");
    prd_t(4'd4, "R5");
    // unmapped words
    pwr(4'd6, 4'hF, 32'hFFFF_FFFF, "R8");
    prd_t(4'd6, "R8");
    hrd_t(3'd7, "R8");

    // random phase with forced address collisions
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] pa;
      logic [2:0] ha;
      pa = 4'($urandom_range(0, 15));
      ha = ($urandom_range(0, 2) == 0) ? pa[2:0] : 3'($urandom_range(0, 7));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, pa, 4'($urandom), $urandom,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ha, 4'($urandom), $urandom,
           4'($urandom & $urandom & $urandom), "");
    end

    // single-port build
    chk("R10", "sp h_rdata", sp_h_rdata, 0);
    sp_access(1, 4'b0000, 32'hFFFF_FFFF, 0, "R10");
    sp_access(0, 4'b0000, 0, 32'h0000_FFFF, "R10");
    sp_access(1, 4'b1010, 32'hA5A5_A5A5, 0, "R10");
    sp_access(1, 4'b0010, 32'hFFFF_FFFF, 0, "R10");
    sp_access(0, 4'b0010, 0, 32'hA5A5_A5A5, "R10");
    sp_access(0, 4'b0001, 0, 32'h0, "R10");
    chk("R10", "sp irqs", {30'h0, sp_p_irq, sp_h_irq}, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule